// File: doc/BRIEF.md
# Byte-wide FPGA configuration port controller

This block drives the byte-wide slave configuration port of a target FPGA from the system clock. It has two jobs. A load command resets the target through its program pin and waits for the init pin to report ready. It then streams the bytes that arrive on an input byte stream onto the configuration data bus, with one low-then-high configuration clock per byte, and clocks all-ones padding until the target reports done. A readback command selects the target, clocks it, and moves one captured byte per configuration clock onto an output byte stream.

The controller is one state machine with these states:

| State | Role |
|-------|------|
| `ST_IDLE` | Waits for a command. `cmd_read_i` picks `ST_RB_SEL` or `ST_PROG_LO`. |
| `ST_PROG_LO` | Holds program low. It goes on to `ST_PROG_REL` after the minimum pulse once init is low. A timeout goes to `ST_ERR`. |
| `ST_PROG_REL` | Releases program and waits for init high, then goes to `ST_LD_CHK`. A timeout goes to `ST_ERR`. |
| `ST_LD_CHK` | The per-byte checks. A zero remaining count or done high goes to `ST_LD_DESEL`. Init low goes to `ST_ERR`. An accepted byte goes to `ST_LD_LO`. |
| `ST_LD_LO`, `ST_LD_HI` | The two clock phases of one byte. `ST_LD_HI` goes on to `ST_LD_BUSY` or `ST_LD_CHK`. |
| `ST_LD_BUSY` | Waits for busy low, then goes to `ST_LD_CHK`. A timeout goes to `ST_ERR`. |
| `ST_LD_DESEL` | Releases select and write. |
| `ST_PAD_CHK`, `ST_PAD_LO`, `ST_PAD_HI` | The padding loop. It leaves for `ST_FIN` after the tail clocks, or for `ST_ERR` on timeout. |
| `ST_RB_SEL`, `ST_RB_LO`, `ST_RB_HI`, `ST_RB_GRAB`, `ST_RB_OUT` | The readback loop. |
| `ST_RB_DLO`, `ST_RB_DHI` | The deselect clock at the end of readback. |
| `ST_FIN`, `ST_ERR` | Both report for one cycle and return to `ST_IDLE`. |

Top module: `pcfg_port_ctrl`

## Requirements
- R1: Out of reset, and whenever idle, program, chip-select and write are high (inactive), the configuration clock is high, the data bus is not driven, and `cmd_ready_o` is high.
- R2: A load holds program low for at least PROG_CYC cycles and until init reads low, then releases it. Write and chip-select fall together, and only after init has read high with program released.
- R3: Each load byte is placed on the data bus before the configuration clock goes low. The bus holds the byte through the low-to-high clock edge, and that edge carries exactly one byte.
- R4: With BUSY_CHECK set, no further byte is clocked while busy is high. If busy stays high for BUSY_TMO cycles, the load ends with error code 4.
- R5: Before each byte, a high done ends streaming early with no error. A low init ends the load with error code 3. A count of zero streams nothing.
- R6: Once streaming stops, chip-select and write rise. The bus carries 8'hFF while the clock keeps toggling with select high.
- R7: After done and init are both seen high in padding, exactly TAIL_CLKS further configuration clocks are given before finishing. Without them for DONE_TMO cycles, the load ends with error code 5.
- R8: Init failing to go low within PROG_CYC+INIT_TMO cycles gives error code 1. Init failing to rise within INIT_TMO cycles after release gives error code 2.
- R9: Readback lowers chip-select while the clock is high and keeps write high. Each byte is one low-high clock followed by a capture of the data bus.
- R10: A captured byte is offered on `out_data_o` with `out_valid_o`. While `out_ready_i` is low, the byte, the valid flag and the clock all hold.
- R11: Readback ends by raising chip-select and giving exactly one low-high clock with select high.
- R12: During readback the data bus is never driven.
- R13: Completion is a single-cycle `fin_o` with `err_o` = 0 on success or the code given above. A zero-length readback returns no bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Start a command (taken when idle) |
| cmd_read_i | input | 1 | 1 = readback, 0 = load |
| cmd_len_i | input | LENW | Byte count |
| cmd_ready_o | output | 1 | Controller idle |
| in_data_i | input | DW | Load byte stream data |
| in_valid_i | input | 1 | Load byte available |
| in_ready_o | output | 1 | Load byte taken this cycle when valid |
| out_data_o | output | DW | Readback byte |
| out_valid_o | output | 1 | Readback byte available |
| out_ready_i | input | 1 | Readback consumer ready |
| fin_o | output | 1 | One-cycle completion pulse |
| err_o | output | 3 | Result code, valid with fin_o |
| prog_n_o | output | 1 | Program pin, active low |
| init_i | input | 1 | Init pin level (high = ready/no error) |
| done_i | input | 1 | Done pin |
| busy_i | input | 1 | Busy pin |
| cs_n_o | output | 1 | Chip-select, active low |
| wr_n_o | output | 1 | Write strobe, active low (high = read) |
| cclk_o | output | 1 | Configuration clock |
| cfg_d_o | output | DW | Data bus output value |
| cfg_d_oe_o | output | 1 | Data bus output enable |
| cfg_d_i | input | DW | Data bus input value |

## Verification
Loads are swept over lengths from 0 to 6, with and without busy stretching and with a stalling input stream. Comparing the received bytes tells apart ordering and per-byte clocking faults, while the busy runs separate flow control from plain streaming. Done is placed at the last byte, before it, and well into padding, which separates early termination from the tail-clock count. Faults are injected one at a time (init never falling, never rising, dropping mid-stream, busy stuck, done never rising) so that each result code is tied to its own wait. Readback lengths 0 to 4 run with a ready and a throttled consumer, which checks byte order, clock holding under backpressure and the single deselect clock.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [2:0] {
        PCFG_OK             = 3'd0,
        PCFG_E_INIT_ASSERT  = 3'd1,
        PCFG_E_INIT_RELEASE = 3'd2,
        PCFG_E_CFG          = 3'd3,
        PCFG_E_BUSY         = 3'd4,
        PCFG_E_DONE         = 3'd5
    } pcfg_err_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_PROG_LO,
        ST_PROG_REL,
        ST_LD_CHK,
        ST_LD_LO,
        ST_LD_HI,
        ST_LD_BUSY,
        ST_LD_DESEL,
        ST_PAD_CHK,
        ST_PAD_LO,
        ST_PAD_HI,
        ST_RB_SEL,
        ST_RB_LO,
        ST_RB_HI,
        ST_RB_GRAB,
        ST_RB_OUT,
        ST_RB_DLO,
        ST_RB_DHI,
        ST_FIN,
        ST_ERR
    } pcfg_state_e;

    function automatic logic in_pad(pcfg_state_e s);
        return (s == ST_PAD_CHK) || (s == ST_PAD_LO) || (s == ST_PAD_HI);
    endfunction

endpackage

// File: rtl/pcfg_wait_timer.sv
module pcfg_wait_timer #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (cnt_q != {W{1'b1}}) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/pcfg_down_cnt.sv
module pcfg_down_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         dec_i,
    output logic [W-1:0] value_o,
    output logic         zero_o
);
    logic [W-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (load_i) begin
            val_q <= load_val_i;
        end else if (dec_i && (val_q != '0)) begin
            val_q <= val_q - 1'b1;
        end
    end

    assign value_o = val_q;
    assign zero_o  = (val_q == '0);
endmodule

// File: rtl/pcfg_port_ctrl.sv
module pcfg_port_ctrl
    import pcfg_pkg::*;
#(
    parameter int DW         = 8,
    parameter int LENW       = 16,
    parameter int TMW        = 32,
    parameter int PROG_CYC   = 32,
    parameter int INIT_TMO   = 50_000_000,
    parameter int BUSY_TMO   = 500_000,
    parameter int DONE_TMO   = 20_000_000,
    parameter int TAIL_CLKS  = 8,
    parameter bit BUSY_CHECK = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid_i,
    input  logic            cmd_read_i,
    input  logic [LENW-1:0] cmd_len_i,
    output logic            cmd_ready_o,
    input  logic [DW-1:0]   in_data_i,
    input  logic            in_valid_i,
    output logic            in_ready_o,
    output logic [DW-1:0]   out_data_o,
    output logic            out_valid_o,
    input  logic            out_ready_i,
    output logic            fin_o,
    output logic [2:0]      err_o,
    output logic            prog_n_o,
    input  logic            init_i,
    input  logic            done_i,
    input  logic            busy_i,
    output logic            cs_n_o,
    output logic            wr_n_o,
    output logic            cclk_o,
    output logic [DW-1:0]   cfg_d_o,
    output logic            cfg_d_oe_o,
    input  logic [DW-1:0]   cfg_d_i
);
    localparam int TAILW = $clog2(TAIL_CLKS + 1);
    localparam logic [TMW-1:0] PROG_MIN  = TMW'(PROG_CYC);
    localparam logic [TMW-1:0] PROG_LIM  = TMW'(PROG_CYC + INIT_TMO);
    localparam logic [TMW-1:0] INIT_LIM  = TMW'(INIT_TMO);
    localparam logic [TMW-1:0] BUSY_LIM  = TMW'(BUSY_TMO);
    localparam logic [TMW-1:0] DONE_LIM  = TMW'(DONE_TMO);
    localparam logic [TAILW-1:0] TAIL_LD = TAILW'(TAIL_CLKS);

    pcfg_state_e st_q, st_d;

    logic [TMW-1:0]  tmr;
    logic            tmr_clr;
    logic [LENW-1:0] len_val;
    logic            len_zero, len_load, len_dec;
    logic [TAILW-1:0] tail_val;
    logic            tail_zero, tail_load, tail_dec;
    logic            byte_take, rb_grab, err_set;
    pcfg_err_e       err_d, err_q;
    logic [DW-1:0]   dq_q, oq_q;
    logic            busy_wait;

    assign busy_wait = BUSY_CHECK;

    // Timer restarts on every state change, except between padding states.
    assign tmr_clr = (st_d != st_q) && !(in_pad(st_d) && in_pad(st_q));

    pcfg_wait_timer #(.W(TMW)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (tmr_clr),
        .count_o (tmr)
    );

    pcfg_down_cnt #(.W(LENW)) u_len (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (len_load),
        .load_val_i (cmd_len_i),
        .dec_i      (len_dec),
        .value_o    (len_val),
        .zero_o     (len_zero)
    );

    pcfg_down_cnt #(.W(TAILW)) u_tail (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tail_load),
        .load_val_i (TAIL_LD),
        .dec_i      (tail_dec),
        .value_o    (tail_val),
        .zero_o     (tail_zero)
    );

    assign in_ready_o = (st_q == ST_LD_CHK) && !len_zero && !done_i && init_i;
    assign byte_take  = in_ready_o && in_valid_i;

    // Next-state logic
    always_comb begin
        st_d      = st_q;
        len_load  = 1'b0;
        len_dec   = 1'b0;
        tail_load = 1'b0;
        tail_dec  = 1'b0;
        rb_grab   = 1'b0;
        err_set   = 1'b0;
        err_d     = err_q;
        unique case (st_q)
            ST_IDLE: begin
                if (cmd_valid_i) begin
                    len_load = 1'b1;
                    st_d     = cmd_read_i ? ST_RB_SEL : ST_PROG_LO;
                end
            end
            ST_PROG_LO: begin
                if ((tmr >= PROG_MIN) && !init_i) begin
                    st_d = ST_PROG_REL;
                end else if (tmr >= PROG_LIM) begin
                    err_set = 1'b1;
                    err_d   = PCFG_E_INIT_ASSERT;
                    st_d    = ST_ERR;
                end
            end
            ST_PROG_REL: begin
                if (init_i) begin
                    st_d = ST_LD_CHK;
                end else if (tmr >= INIT_LIM) begin
                    err_set = 1'b1;
                    err_d   = PCFG_E_INIT_RELEASE;
                    st_d    = ST_ERR;
                end
            end
            ST_LD_CHK: begin
                if (len_zero || done_i) begin
                    st_d = ST_LD_DESEL;
                end else if (!init_i) begin
                    err_set = 1'b1;
                    err_d   = PCFG_E_CFG;
                    st_d    = ST_ERR;
                end else if (in_valid_i) begin
                    st_d = ST_LD_LO;
                end
            end
            ST_LD_LO: st_d = ST_LD_HI;
            ST_LD_HI: begin
                len_dec = 1'b1;
                st_d    = busy_wait ? ST_LD_BUSY : ST_LD_CHK;
            end
            ST_LD_BUSY: begin
                if (!busy_i) begin
                    st_d = ST_LD_CHK;
                end else if (tmr >= BUSY_LIM) begin
                    err_set = 1'b1;
                    err_d   = PCFG_E_BUSY;
                    st_d    = ST_ERR;
                end
            end
            ST_LD_DESEL: begin
                tail_load = 1'b1;
                st_d      = ST_PAD_CHK;
            end
            ST_PAD_CHK: begin
                if (done_i && init_i) begin
                    if (tail_zero) begin
                        st_d = ST_FIN;
                    end else begin
                        tail_dec = 1'b1;
                        st_d     = ST_PAD_LO;
                    end
                end else if (tmr >= DONE_LIM) begin
                    err_set = 1'b1;
                    err_d   = PCFG_E_DONE;
                    st_d    = ST_ERR;
                end else begin
                    st_d = ST_PAD_LO;
                end
            end
            ST_PAD_LO:  st_d = ST_PAD_HI;
            ST_PAD_HI:  st_d = ST_PAD_CHK;
            ST_RB_SEL:  st_d = len_zero ? ST_RB_DLO : ST_RB_LO;
            ST_RB_LO:   st_d = ST_RB_HI;
            ST_RB_HI:   st_d = ST_RB_GRAB;
            ST_RB_GRAB: begin
                rb_grab = 1'b1;
                st_d    = ST_RB_OUT;
            end
            ST_RB_OUT: begin
                if (out_ready_i) begin
                    len_dec = 1'b1;
                    st_d    = (len_val == LENW'(1)) ? ST_RB_DLO : ST_RB_LO;
                end
            end
            ST_RB_DLO:  st_d = ST_RB_DHI;
            ST_RB_DHI:  st_d = ST_FIN;
            ST_FIN:     st_d = ST_IDLE;
            ST_ERR:     st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            err_q <= PCFG_OK;
            dq_q  <= '1;
            oq_q  <= '0;
        end else begin
            st_q <= st_d;
            if (len_load) begin
                err_q <= PCFG_OK;
            end else if (err_set) begin
                err_q <= err_d;
            end
            if (byte_take) begin
                dq_q <= in_data_i;
            end else if (st_q == ST_LD_DESEL) begin
                dq_q <= '1;
            end
            if (rb_grab) begin
                oq_q <= cfg_d_i;
            end
        end
    end

    // Output decode
    always_comb begin
        prog_n_o    = 1'b1;
        cs_n_o      = 1'b1;
        wr_n_o      = 1'b1;
        cclk_o      = 1'b1;
        cfg_d_oe_o  = 1'b0;
        out_valid_o = 1'b0;
        fin_o       = 1'b0;
        cmd_ready_o = 1'b0;
        unique case (st_q)
            ST_IDLE:     cmd_ready_o = 1'b1;
            ST_PROG_LO:  prog_n_o = 1'b0;
            ST_PROG_REL: ;
            ST_LD_CHK, ST_LD_HI, ST_LD_BUSY: begin
                cs_n_o     = 1'b0;
                wr_n_o     = 1'b0;
                cfg_d_oe_o = 1'b1;
            end
            ST_LD_LO: begin
                cs_n_o     = 1'b0;
                wr_n_o     = 1'b0;
                cfg_d_oe_o = 1'b1;
                cclk_o     = 1'b0;
            end
            ST_LD_DESEL, ST_PAD_CHK, ST_PAD_HI: cfg_d_oe_o = 1'b1;
            ST_PAD_LO: begin
                cfg_d_oe_o = 1'b1;
                cclk_o     = 1'b0;
            end
            ST_RB_SEL, ST_RB_HI, ST_RB_GRAB: cs_n_o = 1'b0;
            ST_RB_LO: begin
                cs_n_o = 1'b0;
                cclk_o = 1'b0;
            end
            ST_RB_OUT: begin
                cs_n_o      = 1'b0;
                out_valid_o = 1'b1;
            end
            ST_RB_DLO:   cclk_o = 1'b0;
            ST_RB_DHI:   ;
            ST_FIN, ST_ERR: fin_o = 1'b1;
            default: ;
        endcase
    end

    assign err_o      = err_q;
    assign cfg_d_o    = dq_q;
    assign out_data_o = oq_q;

endmodule

// File: rtl/pcfg_port_ctrl_chk.sv
module pcfg_port_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_ready_o,
    input logic [DW-1:0] out_data_o,
    input logic          out_valid_o,
    input logic          out_ready_i,
    input logic          fin_o,
    input logic          prog_n_o,
    input logic          init_i,
    input logic          cs_n_o,
    input logic          wr_n_o,
    input logic          cclk_o,
    input logic [DW-1:0] cfg_d_o,
    input logic          cfg_d_oe_o
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready_o |-> (prog_n_o && cs_n_o && wr_n_o && cclk_o && !cfg_d_oe_o)); // R1

    AST_WR_AFTER_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_n_o) |-> (init_i && prog_n_o && !cs_n_o)); // R2

    AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cclk_o) && !wr_n_o) |-> $stable(cfg_d_o)); // R3

    AST_PAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (!cclk_o && cs_n_o && cfg_d_oe_o) |-> (cfg_d_o == {DW{1'b1}})); // R6

    AST_RB_SELECT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && wr_n_o) |-> cclk_o); // R9

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(cclk_o))); // R10

    AST_RB_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_o && wr_n_o) |-> !cfg_d_oe_o); // R12

    AST_FIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o); // R13
endmodule

bind pcfg_port_ctrl pcfg_port_ctrl_chk #(.DW(DW)) u_chk (.*);

// File: tb/pcfg_port_ctrl_tb_top.sv
module pcfg_port_ctrl_tb_top;
    localparam int DW = 8;
    localparam int LENW = 8;
    localparam int PROG_CYC = 4;
    localparam int INIT_DLY = 6;
    localparam int TAIL = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid_i = 1'b0, cmd_read_i = 1'b0;
    logic [LENW-1:0] cmd_len_i = '0;
    logic cmd_ready_o;
    logic [DW-1:0] in_data_i = '0;
    logic in_valid_i = 1'b0, in_ready_o;
    logic [DW-1:0] out_data_o;
    logic out_valid_o, out_ready_i = 1'b1;
    logic fin_o;
    logic [2:0] err_o;
    logic prog_n_o, init_i = 1'b1, done_i = 1'b0, busy_i = 1'b0;
    logic cs_n_o, wr_n_o, cclk_o, cfg_d_oe_o;
    logic [DW-1:0] cfg_d_o, cfg_d_i = '0;

    int total = 0, bad = 0;

    pcfg_port_ctrl #(
        .DW(DW), .LENW(LENW), .TMW(16), .PROG_CYC(PROG_CYC), .INIT_TMO(40),
        .BUSY_TMO(20), .DONE_TMO(300), .TAIL_CLKS(TAIL), .BUSY_CHECK(1'b1)
    ) dut_i (.*);

    initial forever #10 clk = ~clk;

    // target model state
    int cfg_done_at, cfg_pad_need, cfg_busy_len, cfg_err_after, cfg_seed;
    bit cfg_busy_stuck, cfg_init_stuck, cfg_init_nolow, cfg_bp, cfg_stall;
    int rx_cnt, pad_cnt, rb_cnt, ob_cnt, ob_bad, viol, oe_bad, prog_low, acc;
    int busy_cnt, init_ctr, cyc;
    bit init_ok = 1'b1, err_flag, cclk_prev = 1'b1;
    logic [DW-1:0] rx_mem [0:15];

    function automatic logic [7:0] ld_pat(int seed, int k);
        return 8'((k * 53 + seed * 17 + 3) & 255);
    endfunction
    function automatic logic [7:0] rb_pat(int seed, int k);
        return 8'(((k * 29 + 7) ^ seed) & 255);
    endfunction

    initial forever begin
        @(negedge clk);
        cyc++;
        out_ready_i = cfg_bp ? ((cyc % 3) == 2) : 1'b1;
        in_valid_i  = cfg_stall ? ((cyc % 2) == 0) : 1'b1;
        in_data_i   = ld_pat(cfg_seed, acc);
        if (in_valid_i && in_ready_o) acc++;
        if (!prog_n_o) begin
            prog_low++;
            init_ok  = cfg_init_nolow;
            init_ctr = 0;
        end else if (!init_ok && !cfg_init_stuck) begin
            init_ctr++;
            if (init_ctr >= INIT_DLY) init_ok = 1'b1;
        end
        if (cclk_o && !cclk_prev) begin
            if (!cs_n_o && !wr_n_o) begin
                if (busy_i) viol++;
                if (rx_cnt < 16) rx_mem[rx_cnt] = cfg_d_o;
                rx_cnt++;
                busy_cnt = cfg_busy_len;
                if (cfg_err_after == rx_cnt) err_flag = 1'b1;
            end else if (!cs_n_o && wr_n_o) begin
                cfg_d_i = rb_pat(cfg_seed, rb_cnt);
                rb_cnt++;
            end else begin
                pad_cnt++;
            end
        end
        cclk_prev = cclk_o;
        if (!cs_n_o && wr_n_o && cfg_d_oe_o) oe_bad++;
        busy_i = cfg_busy_stuck ? (rx_cnt > 0) : (busy_cnt > 0);
        if (busy_cnt > 0) busy_cnt--;
        init_i = init_ok && !err_flag;
        done_i = init_ok && !err_flag && prog_n_o &&
                 ((cfg_done_at >= 0 && rx_cnt >= cfg_done_at) ||
                  (cfg_pad_need >= 0 && pad_cnt >= cfg_pad_need));
        if (out_valid_o && out_ready_i) begin
            if (out_data_o != rb_pat(cfg_seed, ob_cnt)) ob_bad++;
            ob_cnt++;
        end
    end

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic defaults(int seed);
        cfg_done_at = -1; cfg_pad_need = -1; cfg_busy_len = 0; cfg_err_after = -1;
        cfg_seed = seed; cfg_busy_stuck = 0; cfg_init_stuck = 0; cfg_init_nolow = 0;
        cfg_bp = 0; cfg_stall = 0;
    endtask

    // returns the result code, or -1 on watchdog expiry
    task automatic run_cmd(bit rd, int len, output int code);
        @(negedge clk);
        rx_cnt = 0; pad_cnt = 0; rb_cnt = 0; ob_cnt = 0; ob_bad = 0; viol = 0;
        oe_bad = 0; prog_low = 0; acc = 0; busy_cnt = 0; err_flag = 0;
        cmd_read_i = rd; cmd_len_i = LENW'(len); cmd_valid_i = 1'b1;
        @(negedge clk);
        cmd_valid_i = 1'b0;
        code = -1;
        for (int t = 0; t < 5000; t++) begin
            if (fin_o) begin
                code = int'(err_o);
                break;
            end
            @(negedge clk);
        end
        if (code < 0) begin
            total++; bad++;
            $display("FAIL R13: watchdog, actual=no fin expected=fin");
        end
        @(negedge clk);
    endtask

    task automatic load_case(int len, int exp_code, int exp_rx, int exp_pad, string rq);
        int code;
        int mism = 0;
        run_cmd(1'b0, len, code);
        chk({rq, " code"}, code, exp_code);
        chk({rq, " bytes"}, rx_cnt, exp_rx);
        for (int k = 0; k < exp_rx && k < 16; k++)
            if (rx_mem[k] != ld_pat(cfg_seed, k)) mism++;
        chk("R3 data order", mism, 0);
        if (exp_pad >= 0) chk("R7 pad clocks", pad_cnt, exp_pad);
        chk("R4 busy respected", viol, 0);
        chk("R2 prog pulse", int'(prog_low >= PROG_CYC), 1);
    endtask

    initial begin
        int code;
        defaults(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 prog_n", prog_n_o, 1);
        chk("R1 cs_n", cs_n_o, 1);
        chk("R1 wr_n", wr_n_o, 1);
        chk("R1 cclk", cclk_o, 1);
        chk("R1 oe", cfg_d_oe_o, 0);
        chk("R1 ready", cmd_ready_o, 1);

        // R3/R4/R6/R7 sweep of lengths, busy stretch and input stalls
        for (int len = 1; len <= 5; len++) begin
            for (int bl = 0; bl <= 4; bl += 4) begin
                defaults(len * 3 + bl);
                cfg_done_at = len; cfg_busy_len = bl; cfg_stall = (len % 2) == 1;
                load_case(len, 0, len, TAIL, "R3");
            end
        end
        // R5 zero length
        defaults(9); cfg_done_at = 0;
        load_case(0, 0, 0, TAIL, "R5 zero");
        // R5 early done
        defaults(11); cfg_done_at = 3;
        load_case(6, 0, 3, TAIL, "R5 early");
        // R7 done late in padding
        defaults(12); cfg_pad_need = 5;
        load_case(3, 0, 3, 5 + TAIL, "R7 late");
        // R5 init drops mid-stream
        defaults(13); cfg_done_at = 5; cfg_err_after = 2;
        load_case(5, 3, 2, -1, "R5 init");
        // R8 init never rises / never falls
        defaults(14); cfg_init_stuck = 1;
        load_case(2, 2, 0, -1, "R8 release");
        defaults(15); cfg_init_nolow = 1;
        load_case(2, 1, 0, -1, "R8 assert");
        // R4 busy stuck
        defaults(16); cfg_busy_stuck = 1; cfg_done_at = 3;
        run_cmd(1'b0, 3, code);
        chk("R4 busy timeout code", code, 4);
        chk("R4 bytes before stall", rx_cnt, 1);
        // R7 done never
        defaults(17);
        run_cmd(1'b0, 2, code);
        chk("R7 done timeout code", code, 5);

        // R9-R12 readback sweep with and without backpressure
        for (int len = 0; len <= 4; len++) begin
            for (int bp = 0; bp <= 1; bp++) begin
                defaults(20 + len * 2 + bp);
                cfg_bp = bp[0];
                run_cmd(1'b1, len, code);
                chk("R13 rb code", code, 0);
                chk("R10 rb bytes out", ob_cnt, len);
                chk("R10 rb data", ob_bad, 0);
                chk("R9 rb clocks", rb_cnt, len);
                chk("R11 deselect clocks", pad_cnt, 1);
                chk("R12 bus undriven", oe_bad, 0);
            end
        end
        chk("R1 idle after", cmd_ready_o, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule